// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits on the memory path of a host bridge. It classifies each physical address in the legacy window from 0xA0000 to 0xFFFFF. The window has three parts: a 128 KB video hole at 0xA0000–0xBFFFF, twelve 16 KB expansion segments at 0xC0000–0xEFFFF, and one 64 KB top segment at 0xF0000–0xFFFFF. For each access the block returns a routing code:

- 0: DRAM
- 1: DRAM with the write dropped
- 2: forward to the expansion bus

The access is described by its address, a write flag and a system-management-mode (SMM) active level.

Eight byte-wide configuration registers set the decoding. Seven attribute registers at offsets 0x59 to 0x5F hold a 2-bit code for each segment. An SMRAM control register at offset 0x72 decides whether the video hole reaches DRAM. A single-cycle write port loads these registers. The routing output is combinational from the access inputs and the register state, so the bridge can use it in the same cycle as the address.

Top module: `lmr_decoder`

## Requirements
- R1: After reset the attribute registers hold 0x00 and the SMRAM control register holds 0x02. Every access inside the window therefore routes to the bus (code 2), for reads and writes, with SMM low or high.
- R2: An address below 0xA0000 or at or above 0x100000 routes to DRAM (code 0) with `wr_block_o` low. `route_o` never shows code 3.
- R3: The top segment 0xF0000–0xFFFFF takes its 2-bit code from bits 5:4 of register 0x59. The other bits of 0x59 have no effect.
- R4: Segment k (k = 0..11) covers 0xC0000 + k·0x4000 up to 16 KB further. It takes its code from register 0x5A + k/2: bits 1:0 when k is even, bits 5:4 when k is odd. Bits 3:2 and 7:6 have no effect.
- R5: Code 3 routes reads and writes to DRAM (code 0). Code 0 routes reads and writes to the bus (code 2).
- R6: Code 1 routes reads to DRAM (code 0). It routes writes to code 1 with `wr_block_o` high.
- R7: Code 2 routes writes to DRAM (code 0) and reads to the bus (code 2).
- R8: The video hole routes to DRAM when bit 6 of register 0x72 is set, or when bit 3 is set while `smm_act_i` is high. In every other case it routes to the bus.
- R9: A register write takes effect at the clock edge that samples it. The routing in the write's own cycle still reflects the old value. A change of `smm_act_i` affects routing in the same cycle, without a clock edge.
- R10: Writes to offsets other than 0x59–0x5F and 0x72 change no routing.
- R11: `wr_block_o` is high only for a write that routes to code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register offset |
| cfg_wdata_i | input | 8 | Register write data |
| acc_addr_i | input | ADDR_W (32) | Access physical address |
| acc_we_i | input | 1 | Access is a write (1) or a read (0) |
| smm_act_i | input | 1 | System-management mode active |
| route_o | output | 2 | 0 DRAM, 1 DRAM write dropped, 2 bus |
| wr_block_o | output | 1 | Write to a read-only segment was dropped |

## Verification
Two things can land in the same cycle: a register write and an access whose routing that write changes. The bench drives a write to 0x72 or 0x5A together with an access to the affected address. It expects the old routing before the edge and the new routing after it. An SMM toggle in the middle of a cycle must flip the video-hole routing without any edge. Around these cases, swept attribute patterns and every segment boundary are compared against a model that tracks only what the bench has written.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
  typedef enum logic [1:0] {
    ROUTE_DRAM    = 2'd0,
    ROUTE_DRAM_WP = 2'd1,
    ROUTE_BUS     = 2'd2
  } route_e;

  typedef enum logic [1:0] {
    ATTR_BUS = 2'd0,
    ATTR_RO  = 2'd1,
    ATTR_WO  = 2'd2,
    ATTR_RW  = 2'd3
  } attr_e;

  typedef enum logic [1:0] {
    RGN_OUT  = 2'd0,
    RGN_HOLE = 2'd1,
    RGN_ATTR = 2'd2
  } rgn_e;

  localparam logic [7:0] PAM_BASE_OFF = 8'h59;
  localparam logic [7:0] SMRAM_OFF    = 8'h72;
  localparam logic [7:0] SMRAM_RST    = 8'h02;
  localparam int unsigned SMRAM_OPEN_BIT = 6;
  localparam int unsigned SMRAM_SMM_BIT  = 3;
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
  import lmr_pkg::*;
#(
  parameter int unsigned N_PAM = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            addr_i,
  input  logic [7:0]            wdata_i,
  output logic [N_PAM-1:0][7:0] pam_o,
  output logic [7:0]            smram_o
);
  logic [N_PAM-1:0][7:0] pam_q;
  logic [7:0]            smram_q;

  for (genvar g = 0; g < N_PAM; g++) begin : g_pam
    localparam logic [7:0] OFF = PAM_BASE_OFF + 8'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   pam_q[g] <= 8'h00;
      else if (we_i && addr_i == OFF) pam_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          smram_q <= SMRAM_RST;
    else if (we_i && addr_i == SMRAM_OFF) smram_q <= wdata_i;
  end

  assign pam_o   = pam_q;
  assign smram_o = smram_q;
endmodule

// File: rtl/lmr_region_map.sv
module lmr_region_map
  import lmr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SEG_CNT  = 12,
  parameter int unsigned SEG_BITS = 14,
  parameter int unsigned N_PAM    = 1 + SEG_CNT / 2
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [N_PAM-1:0][7:0] pam_i,
  output rgn_e                  rgn_o,
  output logic [1:0]            attr_o
);
  localparam logic [ADDR_W-1:0] HOLE_BASE = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] SEG_BASE  = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] TOP_BASE  = SEG_BASE + ADDR_W'(SEG_CNT << SEG_BITS);
  localparam logic [ADDR_W-1:0] WIN_END   = ADDR_W'(32'h0010_0000);
  localparam int unsigned IDX_W = $clog2(SEG_CNT);

  logic [SEG_CNT-1:0][1:0] seg_attr;
  logic [N_PAM-1:0]        unused_pam;
  logic [IDX_W-1:0]        seg_idx;

  // even segment: low nibble, odd segment: high nibble
  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    assign seg_attr[g] = pam_i[1 + g/2][(g%2)*4 +: 2];
  end

  assign unused_pam[0] = ^{pam_i[0][7:6], pam_i[0][3:0]};
  for (genvar j = 1; j < N_PAM; j++) begin : g_unused
    assign unused_pam[j] = ^{pam_i[j][7:6], pam_i[j][3:2]};
  end

  assign seg_idx = IDX_W'((addr_i - SEG_BASE) >> SEG_BITS);

  always_comb begin
    rgn_o  = RGN_OUT;
    attr_o = 2'd0;
    if (addr_i < HOLE_BASE || addr_i >= WIN_END) begin
      rgn_o = RGN_OUT;
    end else if (addr_i < SEG_BASE) begin
      rgn_o = RGN_HOLE;
    end else if (addr_i >= TOP_BASE) begin
      rgn_o  = RGN_ATTR;
      attr_o = pam_i[0][5:4];
    end else begin
      rgn_o  = RGN_ATTR;
      attr_o = seg_attr[seg_idx];
    end
  end
endmodule

// File: rtl/lmr_attr_resolve.sv
module lmr_attr_resolve
  import lmr_pkg::*;
(
  input  rgn_e       rgn_i,
  input  logic [1:0] attr_i,
  input  logic       we_i,
  input  logic       smm_i,
  input  logic [7:0] smram_i,
  output route_e     route_o,
  output logic       wr_block_o
);
  logic hole_open;
  logic unused_smram;

  assign unused_smram = ^{smram_i[7], smram_i[5:4], smram_i[2:0]};
  assign hole_open = smram_i[SMRAM_OPEN_BIT] | (smram_i[SMRAM_SMM_BIT] & smm_i);

  always_comb begin
    route_o = ROUTE_DRAM;
    unique case (rgn_i)
      RGN_HOLE: route_o = hole_open ? ROUTE_DRAM : ROUTE_BUS;
      RGN_ATTR: begin
        unique case (attr_e'(attr_i))
          ATTR_RW:  route_o = ROUTE_DRAM;
          ATTR_RO:  route_o = we_i ? ROUTE_DRAM_WP : ROUTE_DRAM;
          ATTR_WO:  route_o = we_i ? ROUTE_DRAM : ROUTE_BUS;
          default:  route_o = ROUTE_BUS;
        endcase
      end
      default:  route_o = ROUTE_DRAM;
    endcase
  end

  assign wr_block_o = (route_o == ROUTE_DRAM_WP);
endmodule

// File: rtl/lmr_decoder.sv
module lmr_decoder
  import lmr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SEG_CNT  = 12,
  parameter int unsigned SEG_BITS = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_we_i,
  input  logic              smm_act_i,
  output logic [1:0]        route_o,
  output logic              wr_block_o
);
  localparam int unsigned N_PAM = 1 + SEG_CNT / 2;

  logic [N_PAM-1:0][7:0] pam_q;
  logic [7:0]            smram_q;
  rgn_e                  rgn;
  logic [1:0]            attr;
  route_e                route;

  lmr_cfg_regs #(.N_PAM(N_PAM)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .pam_o   (pam_q),
    .smram_o (smram_q)
  );

  lmr_region_map #(
    .ADDR_W(ADDR_W), .SEG_CNT(SEG_CNT), .SEG_BITS(SEG_BITS), .N_PAM(N_PAM)
  ) u_map (
    .addr_i (acc_addr_i),
    .pam_i  (pam_q),
    .rgn_o  (rgn),
    .attr_o (attr)
  );

  lmr_attr_resolve u_res (
    .rgn_i      (rgn),
    .attr_i     (attr),
    .we_i       (acc_we_i),
    .smm_i      (smm_act_i),
    .smram_i    (smram_q),
    .route_o    (route),
    .wr_block_o (wr_block_o)
  );

  assign route_o = route;
endmodule

// File: rtl/lmr_decoder_chk.sv
module lmr_decoder_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [7:0]        cfg_addr_i,
  input logic [7:0]        cfg_wdata_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_we_i,
  input logic              smm_act_i,
  input logic [1:0]        route_o,
  input logic              wr_block_o,
  input logic [7:0]        smram_q
);
  logic in_win, in_hole;
  logic unused_smram;

  assign unused_smram = ^{smram_q[7], smram_q[5:4], smram_q[2:0]};
  assign in_win  = acc_addr_i >= ADDR_W'(32'h000A_0000) && acc_addr_i < ADDR_W'(32'h0010_0000);
  assign in_hole = acc_addr_i >= ADDR_W'(32'h000A_0000) && acc_addr_i < ADDR_W'(32'h000C_0000);

  assert_outside_dram_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> (route_o == 2'd0 && !wr_block_o));

  assert_legal_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_o != 2'd3);

  assert_block_only_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_o |-> (acc_we_i && route_o == 2'd1));

  assert_smm_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hole && smm_act_i && smram_q[3]) |-> route_o == 2'd0);

  assert_hole_closed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hole && !smram_q[6] && !smram_q[3]) |-> route_o == 2'd2);

  assert_write_next_edge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 8'h72 && cfg_wdata_i[6]) |=> (!in_hole || route_o == 2'd0));
endmodule

bind lmr_decoder lmr_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .acc_addr_i  (acc_addr_i),
  .acc_we_i    (acc_we_i),
  .smm_act_i   (smm_act_i),
  .route_o     (route_o),
  .wr_block_o  (wr_block_o),
  .smram_q     (smram_q)
);

// File: tb/lmr_decoder_bench.sv
`timescale 1ns/1ps
module lmr_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_we_i = 1'b0;
  logic        smm_act_i = 1'b0;
  logic [1:0]  route_o;
  logic        wr_block_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] pam_sh [7];
  logic [7:0] smram_sh;

  always #2.5 clk_i = ~clk_i;

  lmr_decoder u_lmr_decoder (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .acc_addr_i, .acc_we_i, .smm_act_i, .route_o, .wr_block_o
  );

  function automatic logic [1:0] attr_of(input logic [31:0] a);
    int s;
    logic [7:0] b;
    if (a >= 32'hF0000) return pam_sh[0][5:4];
    s = int'((a - 32'hC0000) / 32'h4000);
    b = pam_sh[1 + s/2];
    return (s % 2 == 1) ? b[5:4] : b[1:0];
  endfunction

  // {wr_block, route}
  function automatic logic [2:0] expect_fn(input logic [31:0] a, input logic we, input logic smm);
    logic [1:0] at;
    if (a < 32'hA0000 || a >= 32'h100000) return 3'b000;
    if (a < 32'hC0000) return (smram_sh[6] || (smram_sh[3] && smm)) ? 3'b000 : 3'b010;
    at = attr_of(a);
    case (at)
      2'd3:    return 3'b000;
      2'd1:    return we ? 3'b101 : 3'b000;
      2'd2:    return we ? 3'b000 : 3'b010;
      default: return 3'b010;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    logic [1:0] at;
    if (a < 32'hA0000 || a >= 32'h100000) return "R2";
    if (a < 32'hC0000) return "R8";
    at = attr_of(a);
    return {(a >= 32'hF0000) ? "R3" : "R4", "/",
            (at == 2'd1) ? "R6 R11" : (at == 2'd2) ? "R7" : "R5"};
  endfunction

  task automatic cmp(input string req, input logic [31:0] a, input logic we, input logic smm);
    logic [2:0] e;
    e = expect_fn(a, we, smm);
    n_chk++;
    if (route_o !== e[1:0] || wr_block_o !== e[2]) begin
      n_fail++;
      $display("FAIL %s addr=%h we=%0d smm=%0d actual route=%0d blk=%0d expected route=%0d blk=%0d",
               req, a, we, smm, route_o, wr_block_o, e[1:0], e[2]);
    end
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic we, input logic smm);
    @(negedge clk_i);
    acc_addr_i = a; acc_we_i = we; smm_act_i = smm;
    #1;
    cmp({req, " ", tag_of(a)}, a, we, smm);
  endtask

  task automatic wr_cfg(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = off; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (off >= 8'h59 && off <= 8'h5F) pam_sh[off - 8'h59] = d;
    else if (off == 8'h72) smram_sh = d;
  endtask

  task automatic sweep(input string req);
    for (int sm = 0; sm < 2; sm++) begin
      for (int w = 0; w < 2; w++) begin
        probe(req, 32'h0, w[0], sm[0]);
        probe(req, 32'h9FFFF, w[0], sm[0]);
        probe(req, 32'h100000, w[0], sm[0]);
        probe(req, 32'hFFFFFFFF, w[0], sm[0]);
        probe(req, 32'hA0000, w[0], sm[0]);
        probe(req, 32'hBFFFF, w[0], sm[0]);
        for (int k = 0; k < 12; k++) begin
          probe(req, 32'hC0000 + 32'(k) * 32'h4000, w[0], sm[0]);
          probe(req, 32'hC3FFF + 32'(k) * 32'h4000, w[0], sm[0]);
        end
        probe(req, 32'hF0000, w[0], sm[0]);
        probe(req, 32'hFFFFF, w[0], sm[0]);
      end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) pam_sh[i] = 8'h00;
    smram_sh = 8'h02;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    sweep("R1");

    // uniform codes with don't-care bits set
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 7; r++) wr_cfg(8'h59 + 8'(r), {2'b10, c[1:0], 2'b01, c[1:0]});
      sweep("R5");
    end

    // mixed patterns over attributes and SMRAM control
    for (int p = 0; p < 64; p++) begin
      for (int r = 0; r < 7; r++) wr_cfg(8'h59 + 8'(r), 8'(p * 37 + r * 91) ^ 8'(r << 4));
      wr_cfg(8'h72, {1'b0, p[0], 2'b00, p[1], 3'b010});
      sweep("R4");
    end

    // write and access in the same cycle
    for (int r = 0; r < 7; r++) wr_cfg(8'h59 + 8'(r), 8'h00);
    wr_cfg(8'h72, 8'h00);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 8'h72; cfg_wdata_i = 8'h40;
    acc_addr_i = 32'hA8000; acc_we_i = 1'b0; smm_act_i = 1'b0;
    #1;
    cmp("R9 before edge", 32'hA8000, 1'b0, 1'b0);
    @(negedge clk_i);
    cfg_we_i = 1'b0; smram_sh = 8'h40;
    #1;
    cmp("R9 after edge", 32'hA8000, 1'b0, 1'b0);

    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 8'h5A; cfg_wdata_i = 8'h03;
    acc_addr_i = 32'hC1000; acc_we_i = 1'b1;
    #1;
    cmp("R9 before edge", 32'hC1000, 1'b1, 1'b0);
    @(negedge clk_i);
    cfg_we_i = 1'b0; pam_sh[1] = 8'h03;
    #1;
    cmp("R9 after edge", 32'hC1000, 1'b1, 1'b0);

    // SMM change without an edge
    wr_cfg(8'h72, 8'h08);
    @(negedge clk_i);
    acc_addr_i = 32'hB0000; acc_we_i = 1'b1; smm_act_i = 1'b0;
    #0.5;
    cmp("R9 smm low", 32'hB0000, 1'b1, 1'b0);
    smm_act_i = 1'b1;
    #0.5;
    cmp("R9 smm high", 32'hB0000, 1'b1, 1'b1);
    smm_act_i = 1'b0;
    #0.5;
    cmp("R9 smm low again", 32'hB0000, 1'b1, 1'b0);

    // offsets outside the register set
    for (int r = 0; r < 7; r++) wr_cfg(8'h59 + 8'(r), 8'h00);
    wr_cfg(8'h72, 8'h00);
    wr_cfg(8'h58, 8'hFF);
    wr_cfg(8'h60, 8'hFF);
    wr_cfg(8'h71, 8'hFF);
    wr_cfg(8'h73, 8'hFF);
    wr_cfg(8'h00, 8'hFF);
    wr_cfg(8'hD9, 8'hFF);
    sweep("R10");

    summary();
    $finish;
  end
endmodule